// File: doc/BRIEF.md
# Instruction Buffer Refill Controller

This block decides when and from where a byte-wide instruction prefetch buffer is topped up from word-addressed memory. It watches the buffer occupancy while idle. It issues one or two word fetches, and it asks a page translation unit for a real page whenever a fetch would leave the current page. The block holds the real word PC and the virtual page number. A decoder moves the PC one word forward with a step pulse. A jump or transfer loads a new real PC and virtual page.

Crossing into the next page while the buffer still holds bytes of the current page does not move the PC. The controller fetches word 0 of the translated next page, raises a cross-pending flag and pulses an interrupt request. The PC page bits are then fixed later, at an interrupt check point. If the PC has already left the last word of its page, the check point remaps the PC. If the PC still sits on that word, the check point saves the PC, top-of-stack and stack pointer and keeps the flag. A PC step that wraps the page offset leaves the page bits stale. The next empty-buffer refill remaps the PC before it fetches.

Top module: `ibr_refill_ctrl`

## Requirements
- R1: After reset the controller is idle (busy_o=0), with cross_o=0, irq_o=0, fetch_vld_o=0, xl_req_o=0, rpc_o=0 and vpage_o=0.
- R2: While idle with occ_i of 3 or more, no fetch and no translation request is issued.
- R3: While idle with occ_i of 1 or 2 and the PC offset (low PW bits of rpc_o) not all ones, exactly one fetch at the same page with offset+1 is presented in the cycle after occ_i is sampled. fill_o is high in the cycle after each fetch.
- R4: While idle with occ_i=0, no stale page and the offset not all ones, fetches at rpc_o and at offset+1 are presented in the two cycles after occ_i is sampled.
- R5: A non-empty refill on the last word of a page requests translation of vpage_o+1 in the next cycle. One cycle after the response it fetches word 0 of the returned real page ({rpage, offset 0}) and sets cross_o, with a one-cycle irq_o pulse in the same cycle. rpc_o and vpage_o are left unchanged.
- R6: An empty refill with stale page bits first requests translation of vpage_o+1. One cycle after the response it sets rpc_o to {rpage, offset}, advances vpage_o and fetches that word, then fetches the next word. cross_o stays clear.
- R7: An empty refill on the last word of a page fetches that word first, then requests translation of vpage_o+1. It then fetches word 0 of the returned page and sets cross_o.
- R8: A check pulse (chk_i) with cross_o set and the offset not all ones requests translation of vpage_o+1. On the response it sets rpc_o to {rpage, offset}, advances vpage_o and clears cross_o, with no fetch.
- R9: A check pulse with cross_o set and the offset all ones loads sav_pc_o, sav_tos_o and sav_sp_o from rpc_o, tos_i and sp_i on the next cycle. cross_o stays set and no translation is requested.
- R10: A jump pulse while idle loads rpc_o from jmp_pc_i and vpage_o from jmp_vpage_i, and clears cross_o and the stale mark.
- R11: A step pulse while idle increments the offset of rpc_o modulo the page size and leaves the page bits unchanged. Wrapping from all ones marks the page bits stale.
- R12: xl_req_o stays high until xl_vld_i. While it waits, rpc_o and vpage_o hold, no fetch is presented, and step and jump pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_i | input | OCW | Bytes currently held in the buffer |
| pc_step_i | input | 1 | Advance the PC by one word (idle only) |
| chk_i | input | 1 | Interrupt check point pulse |
| jmp_req_i | input | 1 | Jump or transfer refill request |
| jmp_pc_i | input | AW | New real word PC for a jump |
| jmp_vpage_i | input | VW | New virtual page for a jump |
| tos_i | input | TW | Current top-of-stack value |
| sp_i | input | SW | Current stack pointer |
| xl_vld_i | input | 1 | Translation response valid |
| xl_rpage_i | input | AW-PW | Translated real page |
| xl_req_o | output | 1 | Translation request |
| xl_vpage_o | output | VW | Virtual page to translate |
| fetch_vld_o | output | 1 | Word fetch strobe |
| fetch_addr_o | output | AW | Real word address of the fetch |
| fill_o | output | 1 | Buffer write strobe, one cycle after each fetch |
| rpc_o | output | AW | Real word PC |
| vpage_o | output | VW | Virtual page of the PC |
| cross_o | output | 1 | Cross-pending flag |
| irq_o | output | 1 | Interrupt request pulse |
| busy_o | output | 1 | Controller not idle |
| sav_pc_o | output | AW | Saved PC |
| sav_tos_o | output | TW | Saved top-of-stack |
| sav_sp_o | output | SW | Saved stack pointer |

## Verification
The bench uses 8-word pages and sweeps every virtual page, every starting offset and every occupancy from 0 to 3. The translation reply delay rotates between zero and two cycles. These cases separate the no-refill, single-word, two-word and crossing paths, and they show whether a cross is placed between the two words of an empty refill or on the single word of a non-empty one. The cross-pending cases then drive a check pulse on the last word and, after a wrapping step, a second check pulse, which tells the save path apart from the remap path. A separate pass wraps the PC of every page and then refills an empty buffer to exercise the stale-page remap. Step pulses driven during translation waits confirm that the PC is held.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XWAIT,
    ST_E2,
    ST_DONE,
    ST_SETTLE
  } ibr_st_e;

  typedef enum logic [1:0] {
    XP_REMAP,
    XP_NEXT,
    XP_FIX
  } ibr_xp_e;
endpackage

// File: rtl/ibr_addr.sv
module ibr_addr #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-PW-1:0] rpage_i,
  output logic             off_last_o,
  output logic [AW-1:0]    step_o,
  output logic [AW-1:0]    remap_o,
  output logic [AW-1:0]    pg0_o
);
  logic [PW-1:0] off;
  logic [PW:0]   off_inc;

  assign off        = pc_i[PW-1:0];
  assign off_inc    = {1'b0, off} + 1'b1;
  assign off_last_o = off_inc[PW];
  assign step_o     = {pc_i[AW-1:PW], off_inc[PW-1:0]};
  assign remap_o    = {rpage_i, off};
  assign pg0_o      = {rpage_i, {PW{1'b0}}};
endmodule

// File: rtl/ibr_save.sv
module ibr_save #(
  parameter int AW = 16,
  parameter int TW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [AW-1:0] pc_i,
  input  logic [TW-1:0] tos_i,
  input  logic [SW-1:0] sp_i,
  output logic [AW-1:0] pc_o,
  output logic [TW-1:0] tos_o,
  output logic [SW-1:0] sp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o  <= '0;
      tos_o <= '0;
      sp_o  <= '0;
    end else if (en_i) begin
      pc_o  <= pc_i;
      tos_o <= tos_i;
      sp_o  <= sp_i;
    end
  end
endmodule

// File: rtl/ibr_refill_ctrl.sv
module ibr_refill_ctrl
  import ibr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int PW  = 8,
  parameter int VW  = 8,
  parameter int TW  = 16,
  parameter int SW  = 8,
  parameter int OCW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCW-1:0]   occ_i,
  input  logic             pc_step_i,
  input  logic             chk_i,
  input  logic             jmp_req_i,
  input  logic [AW-1:0]    jmp_pc_i,
  input  logic [VW-1:0]    jmp_vpage_i,
  input  logic [TW-1:0]    tos_i,
  input  logic [SW-1:0]    sp_i,
  input  logic             xl_vld_i,
  input  logic [AW-PW-1:0] xl_rpage_i,
  output logic             xl_req_o,
  output logic [VW-1:0]    xl_vpage_o,
  output logic             fetch_vld_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             fill_o,
  output logic [AW-1:0]    rpc_o,
  output logic [VW-1:0]    vpage_o,
  output logic             cross_o,
  output logic             irq_o,
  output logic             busy_o,
  output logic [AW-1:0]    sav_pc_o,
  output logic [TW-1:0]    sav_tos_o,
  output logic [SW-1:0]    sav_sp_o
);
  localparam logic [OCW-1:0] LOW_MARK = OCW'(3);

  ibr_st_e       st;
  ibr_xp_e       xp;
  logic          stale;
  logic          off_last;
  logic [AW-1:0] step_addr, remap_addr, pg0_addr;
  logic          save_en;

  ibr_addr #(.AW(AW), .PW(PW)) u_addr (
    .pc_i       (rpc_o),
    .rpage_i    (xl_rpage_i),
    .off_last_o (off_last),
    .step_o     (step_addr),
    .remap_o    (remap_addr),
    .pg0_o      (pg0_addr)
  );

  assign save_en = (st == ST_IDLE) && !jmp_req_i && !pc_step_i &&
                   chk_i && cross_o && off_last;

  ibr_save #(.AW(AW), .TW(TW), .SW(SW)) u_save (
    .clk   (clk),
    .rst   (rst),
    .en_i  (save_en),
    .pc_i  (rpc_o),
    .tos_i (tos_i),
    .sp_i  (sp_i),
    .pc_o  (sav_pc_o),
    .tos_o (sav_tos_o),
    .sp_o  (sav_sp_o)
  );

  assign busy_o = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      xp           <= XP_FIX;
      rpc_o        <= '0;
      vpage_o      <= '0;
      stale        <= 1'b0;
      cross_o      <= 1'b0;
      irq_o        <= 1'b0;
      fetch_vld_o  <= 1'b0;
      fetch_addr_o <= '0;
      fill_o       <= 1'b0;
      xl_req_o     <= 1'b0;
      xl_vpage_o   <= '0;
    end else begin
      irq_o       <= 1'b0;
      fill_o      <= fetch_vld_o;
      fetch_vld_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (jmp_req_i) begin
            rpc_o   <= jmp_pc_i;
            vpage_o <= jmp_vpage_i;
            cross_o <= 1'b0;
            stale   <= 1'b0;
          end else if (pc_step_i) begin
            rpc_o <= step_addr;
            if (off_last) stale <= 1'b1;
          end else if (chk_i && cross_o) begin
            if (!off_last) begin
              xl_req_o   <= 1'b1;
              xl_vpage_o <= vpage_o + 1'b1;
              xp         <= XP_FIX;
              st         <= ST_XWAIT;
            end
          end else if (occ_i == '0) begin
            if (stale) begin
              xl_req_o   <= 1'b1;
              xl_vpage_o <= vpage_o + 1'b1;
              xp         <= XP_REMAP;
              st         <= ST_XWAIT;
            end else begin
              fetch_vld_o  <= 1'b1;
              fetch_addr_o <= rpc_o;
              st           <= ST_E2;
            end
          end else if (occ_i < LOW_MARK) begin
            if (off_last) begin
              xl_req_o   <= 1'b1;
              xl_vpage_o <= vpage_o + 1'b1;
              xp         <= XP_NEXT;
              st         <= ST_XWAIT;
            end else begin
              fetch_vld_o  <= 1'b1;
              fetch_addr_o <= step_addr;
              st           <= ST_DONE;
            end
          end
        end
        ST_XWAIT: begin
          if (xl_vld_i) begin
            xl_req_o <= 1'b0;
            case (xp)
              XP_REMAP: begin
                rpc_o        <= remap_addr;
                vpage_o      <= xl_vpage_o;
                stale        <= 1'b0;
                fetch_vld_o  <= 1'b1;
                fetch_addr_o <= remap_addr;
                st           <= ST_E2;
              end
              XP_NEXT: begin
                fetch_vld_o  <= 1'b1;
                fetch_addr_o <= pg0_addr;
                cross_o      <= 1'b1;
                irq_o        <= 1'b1;
                st           <= ST_DONE;
              end
              default: begin
                rpc_o   <= remap_addr;
                vpage_o <= xl_vpage_o;
                stale   <= 1'b0;
                cross_o <= 1'b0;
                st      <= ST_IDLE;
              end
            endcase
          end
        end
        ST_E2: begin
          if (off_last) begin
            xl_req_o   <= 1'b1;
            xl_vpage_o <= vpage_o + 1'b1;
            xp         <= XP_NEXT;
            st         <= ST_XWAIT;
          end else begin
            fetch_vld_o  <= 1'b1;
            fetch_addr_o <= step_addr;
            st           <= ST_DONE;
          end
        end
        ST_DONE:   st <= ST_SETTLE;
        ST_SETTLE: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ibr_chk.sv
module ibr_chk #(
  parameter int AW = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          jmp_req_i,
  input logic          xl_vld_i,
  input logic          xl_req_o,
  input logic          fetch_vld_o,
  input logic          fill_o,
  input logic [AW-1:0] rpc_o,
  input logic [VW-1:0] vpage_o,
  input logic          cross_o,
  input logic          irq_o,
  input logic          busy_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy_o && !cross_o && !irq_o && !fetch_vld_o && !xl_req_o));

  a_r2_no_fetch_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !fetch_vld_o);

  a_r3_fill_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_vld_o |=> fill_o);

  a_r5_irq_with_cross: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> cross_o);

  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r10_jump_clears: assert property (@(posedge clk) disable iff (rst)
    (jmp_req_i && !busy_o) |=> !cross_o);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xl_req_o && !xl_vld_i) |=> xl_req_o);

  a_r12_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (xl_req_o && !xl_vld_i) |=> ($stable(rpc_o) && $stable(vpage_o)));

  a_r12_no_fetch_wait: assert property (@(posedge clk) disable iff (rst)
    xl_req_o |-> !fetch_vld_o);
endmodule

bind ibr_refill_ctrl ibr_chk #(.AW(AW), .VW(VW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .jmp_req_i   (jmp_req_i),
  .xl_vld_i    (xl_vld_i),
  .xl_req_o    (xl_req_o),
  .fetch_vld_o (fetch_vld_o),
  .fill_o      (fill_o),
  .rpc_o       (rpc_o),
  .vpage_o     (vpage_o),
  .cross_o     (cross_o),
  .irq_o       (irq_o),
  .busy_o      (busy_o)
);

// File: tb/tb_ibr_refill_ctrl.sv
module tb_ibr_refill_ctrl;
  localparam int AW = 8, PW = 3, VW = 4, TW = 8, SW = 4, OCW = 3;
  localparam int RW = AW - PW;
  localparam int LAST = (1 << PW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [OCW-1:0] occ_i = 3;
  logic pc_step_i = 0, chk_i = 0, jmp_req_i = 0, xl_vld_i = 0;
  logic [AW-1:0] jmp_pc_i = '0;
  logic [VW-1:0] jmp_vpage_i = '0;
  logic [TW-1:0] tos_i = '0;
  logic [SW-1:0] sp_i = '0;
  logic [RW-1:0] xl_rpage_i = '0;
  logic xl_req_o, fetch_vld_o, fill_o, cross_o, irq_o, busy_o;
  logic [VW-1:0] xl_vpage_o, vpage_o;
  logic [AW-1:0] fetch_addr_o, rpc_o, sav_pc_o;
  logic [TW-1:0] sav_tos_o;
  logic [SW-1:0] sav_sp_o;

  ibr_refill_ctrl #(.AW(AW), .PW(PW), .VW(VW), .TW(TW), .SW(SW), .OCW(OCW)) dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int nf, fa0, fa1, fc0, fc1, nreq, reqv, reqc, nirq, irqc, nfill, moved;

  function automatic int xlat(input int v);
    return (v * 5 + 3) % (1 << RW);
  endfunction

  function automatic int mkpc(input int pg, input int off);
    return (pg << PW) | off;
  endfunction

  task automatic ceq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic window(input int n, input int dly, input bit set_full);
    int wc, hold_pc, hold_vp;
    bit prev;
    wc = 0; prev = 0; hold_pc = 0; hold_vp = 0;
    nf = 0; fa0 = -1; fa1 = -1; fc0 = -1; fc1 = -1; nreq = 0; reqv = -1;
    reqc = -1; nirq = 0; irqc = -1; nfill = 0; moved = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk_i = 0;
      if (fetch_vld_o) begin
        if (nf == 0) begin fa0 = int'(fetch_addr_o); fc0 = k; end
        else if (nf == 1) begin fa1 = int'(fetch_addr_o); fc1 = k; end
        nf++;
        if (set_full) occ_i = 3;
      end
      if (fill_o) nfill++;
      if (irq_o) begin nirq++; irqc = k; end
      if (xl_req_o) begin
        if (!prev) begin
          nreq++; reqv = int'(xl_vpage_o); reqc = k;
          hold_pc = int'(rpc_o); hold_vp = int'(vpage_o); wc = 0;
        end
        if (int'(rpc_o) != hold_pc || int'(vpage_o) != hold_vp) moved = 1;
        if (wc == dly) begin
          xl_vld_i = 1; xl_rpage_i = RW'(xlat(int'(xl_vpage_o))); pc_step_i = 0;
        end else begin
          wc++; pc_step_i = 1;
        end
      end else begin
        xl_vld_i = 0; pc_step_i = 0;
      end
      prev = xl_req_o;
    end
    xl_vld_i = 0; pc_step_i = 0;
  endtask

  task automatic do_jump(input int pc, input int vp);
    occ_i = 3;
    @(negedge clk);
    jmp_req_i = 1; jmp_pc_i = AW'(pc); jmp_vpage_i = VW'(vp);
    @(negedge clk);
    jmp_req_i = 0;
  endtask

  task automatic do_step();
    @(negedge clk);
    pc_step_i = 1;
    @(negedge clk);
    pc_step_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R12 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    ceq("R1 busy", busy_o, 0);
    ceq("R1 cross", cross_o, 0);
    ceq("R1 irq", irq_o, 0);
    ceq("R1 fetch", fetch_vld_o, 0);
    ceq("R1 xreq", xl_req_o, 0);
    ceq("R1 rpc", int'(rpc_o), 0);
    ceq("R1 vpage", int'(vpage_o), 0);

    for (int v = 0; v < (1 << VW); v++) begin
      for (int off = 0; off <= LAST; off++) begin
        for (int oc = 0; oc < 4; oc++) begin
          int d, vn, pg, pgn;
          d = (v + off) % 3;
          vn = (v + 1) % (1 << VW);
          pg = xlat(v); pgn = xlat(vn);
          do_jump(mkpc(pg, off), v);
          ceq("R10 rpc", int'(rpc_o), mkpc(pg, off));
          ceq("R10 vpage", int'(vpage_o), v);
          ceq("R10 cross", cross_o, 0);
          occ_i = OCW'(oc);
          window(12, d, 1'b1);
          ceq("R12 pc held", moved, 0);
          ceq("R3 busy end", busy_o, 0);
          if (oc == 3) begin
            ceq("R2 fetches", nf, 0);
            ceq("R2 requests", nreq, 0);
          end else if (oc > 0 && off != LAST) begin
            ceq("R3 count", nf, 1);
            ceq("R3 addr", fa0, mkpc(pg, off + 1));
            ceq("R3 cycle", fc0, 1);
            ceq("R3 fill", nfill, 1);
            ceq("R3 noreq", nreq, 0);
          end else if (oc == 0 && off != LAST) begin
            ceq("R4 count", nf, 2);
            ceq("R4 addr0", fa0, mkpc(pg, off));
            ceq("R4 cyc0", fc0, 1);
            ceq("R4 addr1", fa1, mkpc(pg, off + 1));
            ceq("R4 cyc1", fc1, 2);
            ceq("R4 cross", cross_o, 0);
          end else if (oc > 0) begin
            ceq("R5 req", nreq, 1);
            ceq("R5 reqv", reqv, vn);
            ceq("R5 reqc", reqc, 1);
            ceq("R5 count", nf, 1);
            ceq("R5 addr", fa0, mkpc(pgn, 0));
            ceq("R5 cyc", fc0, 2 + d);
            ceq("R5 irq", nirq, 1);
            ceq("R5 irqc", irqc, 2 + d);
            ceq("R5 cross", cross_o, 1);
            ceq("R5 rpc kept", int'(rpc_o), mkpc(pg, off));
            ceq("R5 vpage kept", int'(vpage_o), v);
            // R9 save on last word
            tos_i = TW'(v * 7 + oc); sp_i = SW'(v + off);
            @(negedge clk); chk_i = 1;
            @(negedge clk); chk_i = 0;
            ceq("R9 sav pc", int'(sav_pc_o), mkpc(pg, off));
            ceq("R9 sav tos", int'(sav_tos_o), (v * 7 + oc) % (1 << TW));
            ceq("R9 sav sp", int'(sav_sp_o), (v + off) % (1 << SW));
            ceq("R9 cross", cross_o, 1);
            ceq("R9 noreq", xl_req_o, 0);
            // R11 wrap keeps page bits
            do_step();
            ceq("R11 wrap", int'(rpc_o), mkpc(pg, 0));
            // R8 fix at check point
            @(negedge clk); chk_i = 1;
            window(6, 0, 1'b0);
            ceq("R8 req", nreq, 1);
            ceq("R8 reqv", reqv, vn);
            ceq("R8 rpc", int'(rpc_o), mkpc(pgn, 0));
            ceq("R8 vpage", int'(vpage_o), vn);
            ceq("R8 cross", cross_o, 0);
            ceq("R8 nofetch", nf, 0);
          end else begin
            ceq("R7 count", nf, 2);
            ceq("R7 addr0", fa0, mkpc(pg, LAST));
            ceq("R7 cyc0", fc0, 1);
            ceq("R7 reqv", reqv, vn);
            ceq("R7 reqc", reqc, 2);
            ceq("R7 addr1", fa1, mkpc(pgn, 0));
            ceq("R7 cyc1", fc1, 3 + d);
            ceq("R7 cross", cross_o, 1);
            ceq("R7 irq", nirq, 1);
          end
        end
      end
    end

    // R6 stale page remap on empty refill; R11 step inside a page
    for (int v = 0; v < (1 << VW); v++) begin
      int d, vn, pg, pgn;
      d = v % 3;
      vn = (v + 1) % (1 << VW);
      pg = xlat(v); pgn = xlat(vn);
      do_jump(mkpc(pg, LAST - 1), v);
      do_step();
      ceq("R11 step", int'(rpc_o), mkpc(pg, LAST));
      do_step();
      ceq("R11 wrap", int'(rpc_o), mkpc(pg, 0));
      ceq("R11 vpage", int'(vpage_o), v);
      occ_i = 0;
      window(12, d, 1'b1);
      ceq("R6 req", nreq, 1);
      ceq("R6 reqv", reqv, vn);
      ceq("R6 reqc", reqc, 1);
      ceq("R6 count", nf, 2);
      ceq("R6 addr0", fa0, mkpc(pgn, 0));
      ceq("R6 cyc0", fc0, 2 + d);
      ceq("R6 addr1", fa1, mkpc(pgn, 1));
      ceq("R6 cyc1", fc1, 3 + d);
      ceq("R6 rpc", int'(rpc_o), mkpc(pgn, 0));
      ceq("R6 vpage", int'(vpage_o), vn);
      ceq("R6 cross", cross_o, 0);
      ceq("R12 pc held", moved, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule